// File: doc/BRIEF.md
# Peripheral Request Timeout Monitor

This block watches two DMA channels while each one is stalled, waiting for its peripheral to raise a request. Every channel runs a power-of-two prescaler that turns the system clock into a slow tick. A 16-bit counter counts those ticks. If the programmed number of ticks passes without a request, the channel's sticky timeout flag is raised. An optional interrupt is raised from that flag.

Software programs the monitor through four write-only words. These are the prescaler select word, the period word, a control word that holds the function and interrupt enables, and a flag word where writing 1 clears a flag. The flags and the combined interrupt are the only outputs. The surrounding DMA engine drives the per-channel "waiting" and "request seen" strobes.

Top module: `req_timeout_mon`

## Requirements
- R1: The prescaler select n of channel 0 sits in bits 2:0 and that of channel 1 in bits 6:4 of the prescaler word. Value n makes one tick last 2^(8+n) clock cycles, from 256 (n=0) up to 32768 (n=7).
- R2: The period P of channel 0 sits in bits 15:0 and that of channel 1 in bits 31:16 of the period word. The flag rises at the P*2^(8+n)-th consecutive rising edge that samples the channel enabled, waiting and without a request.
- R3: The function enables sit in bits 0 (channel 0) and 1 (channel 1) of the control word. While a channel's enable is 0 its counter stays at zero and its flag never rises.
- R4: Writing the flag word clears the flag of channel 0 if bit 8 is 1 and the flag of channel 1 if bit 9 is 1. A 0 in either bit leaves that flag unchanged.
- R5: A request strobe, or the waiting strobe going low, restarts the count from zero.
- R6: Once a flag is set the count is held at zero. Continued waiting raises no new event. After the flag is cleared, a full period is needed before it rises again.
- R7: The interrupt enables sit in bits 8 (channel 0) and 9 (channel 1) of the control word. The interrupt output is the OR over channels of flag AND interrupt enable.
- R8: If a clear of a flag and a new timeout of the same channel fall on one edge, the flag ends up set.
- R9: A period of zero never raises the flag.
- R10: After reset, both flags, the interrupt and all configuration fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_i | input | 2 | Per channel: channel is waiting for its peripheral request |
| req_i | input | 2 | Per channel: peripheral request seen this cycle |
| psc_we | input | 1 | Write strobe of the prescaler word |
| psc_wdata | input | 32 | Prescaler word data |
| per_we | input | 1 | Write strobe of the period word |
| per_wdata | input | 32 | Period word data |
| ctl_we | input | 1 | Write strobe of the control word |
| ctl_wdata | input | 32 | Control word data |
| clr_we | input | 1 | Write strobe of the flag-clear word |
| clr_wdata | input | 32 | Flag-clear word data |
| tmo_flag_o | output | 2 | Sticky timeout flags |
| irq_o | output | 1 | Combined timeout interrupt |

## Verification
The assertions take for granted that the prescaler select and the period of a channel are not rewritten while that channel is counting. The tick comparison is an equality, so shrinking a field mid-wait would move the deadline. The stimulus changes those fields only while the channel's waiting strobe is low, or while its flag is already set. Request and waiting strobes are driven on the falling edge and held for whole cycles. A clear write is deliberately landed on the exact edge of a timeout, to exercise the collision rule.

// File: rtl/req_timeout_mon.sv
`timescale 1ns/1ps
module req_timeout_mon #(
  parameter int NCH    = 2,
  parameter int PSW    = 3,
  parameter int PERW   = 16,
  parameter int PSBASE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  wait_i,
  input  logic [NCH-1:0]  req_i,
  input  logic            psc_we,
  input  logic [31:0]     psc_wdata,
  input  logic            per_we,
  input  logic [31:0]     per_wdata,
  input  logic            ctl_we,
  input  logic [31:0]     ctl_wdata,
  input  logic            clr_we,
  input  logic [31:0]     clr_wdata,
  output logic [NCH-1:0]  tmo_flag_o,
  output logic            irq_o
);
  localparam int PCW     = PSBASE + (1 << PSW) - 1;
  localparam int FLAGPOS = 8;
  localparam int IEPOS   = 8;

  logic [NCH-1:0] en_q, ie_q, per_zero;
  logic unused_bits;
  assign unused_bits = ^{psc_wdata, per_wdata, ctl_wdata, clr_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      ie_q <= '0;
    end else if (ctl_we) begin
      en_q <= ctl_wdata[NCH-1:0];
      ie_q <= ctl_wdata[IEPOS +: NCH];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [PSW-1:0]  ps_q;
    logic [PERW-1:0] per_q, tc_q;
    logic [PCW-1:0]  pc_q;
    logic [PCW:0]    div_m1;
    logic            flag_q, restart, run, tick_last, fire, clr_hit;

    assign div_m1    = ({{PCW{1'b0}}, 1'b1} << (PSBASE + int'(ps_q))) - 1'b1;
    assign tick_last = (pc_q == div_m1[PCW-1:0]);
    assign restart   = !en_q[i] || !wait_i[i] || req_i[i];
    assign run       = !restart && !flag_q && (per_q != '0);
    assign fire      = run && tick_last && (tc_q == per_q - 1'b1);
    assign clr_hit   = clr_we && clr_wdata[FLAGPOS + i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ps_q  <= '0;
        per_q <= '0;
      end else begin
        if (psc_we) ps_q  <= psc_wdata[4*i +: PSW];
        if (per_we) per_q <= per_wdata[PERW*i +: PERW];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
        pc_q <= '0;
        tc_q <= '0;
      end else if (run) begin
        if (tick_last) begin
          pc_q <= '0;
          tc_q <= fire ? '0 : tc_q + 1'b1;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (fire)    flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
    end

    assign tmo_flag_o[i] = flag_q;
    assign per_zero[i]   = (per_q == '0);
  end

  assign irq_o = |(tmo_flag_o & ie_q);
endmodule

module req_timeout_mon_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] wait_i,
  input logic [NCH-1:0] req_i,
  input logic           clr_we,
  input logic [31:0]    clr_wdata,
  input logic [NCH-1:0] tmo_flag_o,
  input logic           irq_o,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] per_zero
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_flag_o[i]) |-> $past(clr_we && clr_wdata[8+i]));
    a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag_o[i]) |-> $past(en_q[i] && wait_i[i]));
    a_r5_rise_without_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag_o[i]) |-> $past(!req_i[i]));
    a_r9_zero_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (per_zero[i] && !tmo_flag_o[i]) |=> !tmo_flag_o[i]);
  end
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (tmo_flag_o != '0));
endmodule

bind req_timeout_mon req_timeout_mon_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/req_timeout_mon_tb.sv
`timescale 1ns/1ps
module req_timeout_mon_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] wait_i = '0, req_i = '0;
  logic psc_we = 0, per_we = 0, ctl_we = 0, clr_we = 0;
  logic [31:0] psc_wdata = '0, per_wdata = '0, ctl_wdata = '0, clr_wdata = '0;
  logic [1:0] tmo_flag_o;
  logic irq_o;

  int nchk = 0, nfail = 0;
  bit done = 0;

  req_timeout_mon u_dut (.*);

  always #2.5 clk = ~clk;

  longint cnt [2];
  bit mflag [2], men [2], mie [2];
  int mps [2], mper [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cnt[i] = 0; mflag[i] = 0; men[i] = 0; mie[i] = 0; mps[i] = 0; mper[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit set;
        set = 0;
        if (!men[i] || !wait_i[i] || req_i[i]) cnt[i] = 0;
        else if (!mflag[i] && mper[i] != 0) begin
          cnt[i]++;
          if (cnt[i] == longint'(mper[i]) * (longint'(1) << (8 + mps[i]))) begin
            set = 1; cnt[i] = 0;
          end
        end
        if (set) mflag[i] = 1;
        else if (clr_we && clr_wdata[8+i]) mflag[i] = 0;
      end
      for (int i = 0; i < 2; i++) begin
        if (psc_we) mps[i]  = int'(psc_wdata[4*i +: 3]);
        if (per_we) mper[i] = int'(per_wdata[16*i +: 16]);
        if (ctl_we) begin men[i] = ctl_wdata[i]; mie[i] = ctl_wdata[8+i]; end
      end
    end
  end

  task automatic check(input string tag, input logic a, input logic e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model flag ch0", tmo_flag_o[0], mflag[0]);
      check("R2 model flag ch1", tmo_flag_o[1], mflag[1]);
      check("R7 model irq", irq_o, (mflag[0] & mie[0]) | (mflag[1] & mie[1]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    case (sel)
      0: begin psc_we = 1; psc_wdata = d; end
      1: begin per_we = 1; per_wdata = d; end
      2: begin ctl_we = 1; ctl_wdata = d; end
      default: begin clr_we = 1; clr_wdata = d; end
    endcase
    @(negedge clk);
    psc_we = 0; per_we = 0; ctl_we = 0; clr_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    check("R10 reset flag ch0", tmo_flag_o[0], 1'b0);
    check("R10 reset flag ch1", tmo_flag_o[1], 1'b0);
    check("R10 reset irq", irq_o, 1'b0);

    wr(2, 32'h0000_0103);
    wr(0, 32'h0000_0010);
    wr(1, 32'h0002_0003);

    wait_i[0] = 1;
    cyc(767);
    check("R2 ch0 before deadline", tmo_flag_o[0], 1'b0);
    cyc(1);
    check("R2 ch0 at deadline", tmo_flag_o[0], 1'b1);
    check("R1 tick of 256 clocks", tmo_flag_o[0], 1'b1);
    check("R7 irq with ie0", irq_o, 1'b1);

    cyc(1000);
    check("R6 flag held while waiting", tmo_flag_o[0], 1'b1);
    wr(3, 32'h0000_0200);
    check("R4 zero bit no effect", tmo_flag_o[0], 1'b1);
    wr(3, 32'h0000_0100);
    check("R4 write one clears", tmo_flag_o[0], 1'b0);
    cyc(767);
    check("R6 full period after clear", tmo_flag_o[0], 1'b0);
    cyc(1);
    check("R6 second event", tmo_flag_o[0], 1'b1);
    wait_i[0] = 0;
    wr(3, 32'h0000_0100);

    wait_i[0] = 1;
    cyc(500);
    req_i[0] = 1;
    cyc(1);
    req_i[0] = 0;
    cyc(767);
    check("R5 request restarts", tmo_flag_o[0], 1'b0);
    cyc(1);
    check("R5 flag after restart", tmo_flag_o[0], 1'b1);
    wr(3, 32'h0000_0100);
    cyc(500);
    wait_i[0] = 0;
    cyc(1);
    wait_i[0] = 1;
    cyc(767);
    check("R5 wait drop restarts", tmo_flag_o[0], 1'b0);
    cyc(1);
    check("R5 flag after wait drop", tmo_flag_o[0], 1'b1);
    wait_i[0] = 0;
    wr(3, 32'h0000_0100);

    wr(2, 32'h0000_0102);
    wait_i[0] = 1;
    cyc(2000);
    check("R3 disabled no timeout", tmo_flag_o[0], 1'b0);
    wr(2, 32'h0000_0103);
    cyc(767);
    check("R3 re-enabled before deadline", tmo_flag_o[0], 1'b0);
    cyc(1);
    check("R3 re-enabled timeout", tmo_flag_o[0], 1'b1);
    wait_i[0] = 0;
    wr(3, 32'h0000_0100);

    wait_i[1] = 1;
    cyc(1023);
    check("R2 ch1 upper half period", tmo_flag_o[1], 1'b0);
    cyc(1);
    check("R1 ch1 tick of 512", tmo_flag_o[1], 1'b1);
    check("R7 irq masked by ie1", irq_o, 1'b0);
    wr(2, 32'h0000_0303);
    check("R7 irq with ie1", irq_o, 1'b1);
    wait_i[1] = 0;
    wr(3, 32'h0000_0200);

    wait_i[0] = 1;
    cyc(767);
    clr_we = 1; clr_wdata = 32'h0000_0100;
    cyc(1);
    clr_we = 0; clr_wdata = '0;
    check("R8 set wins over clear", tmo_flag_o[0], 1'b1);
    wait_i[0] = 0;
    wr(3, 32'h0000_0100);

    wr(1, 32'h0001_0000);
    wait_i[0] = 1;
    cyc(3000);
    check("R9 zero period silent", tmo_flag_o[0], 1'b0);
    wait_i[0] = 0;

    wr(0, 32'h0000_0070);
    wait_i[1] = 1;
    cyc(32767);
    check("R1 ch1 32768 before", tmo_flag_o[1], 1'b0);
    cyc(1);
    check("R1 ch1 32768 at", tmo_flag_o[1], 1'b1);
    wait_i[1] = 0;
    cyc(2);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule